// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block performs unsigned 8-bit by 8-bit multiplication and division on behalf of an accumulator-style datapath. The surrounding core presents the accumulator value and the auxiliary register value on two operand inputs. It selects the operation and raises a start request for one cycle. After a fixed number of clock cycles, the unit returns the new accumulator and auxiliary values together with a carry flag and an overflow flag, and it marks that moment with a one-cycle done pulse.

Multiplication is done by shift-and-add and division by restoring division. Each method retires one bit per clock and uses the same pair of working registers. For a product, the low byte returns as the new accumulator and the high byte as the new auxiliary value. For a quotient, the quotient returns as the new accumulator and the remainder as the new auxiliary value. The flags follow per-operation rules: overflow marks a product that does not fit in one byte, or an attempt to divide by zero. The unit does not fetch or decode instructions, does not write any register file, and supports no signed forms.

Top module: `md_unit`

## Requirements
- R1: After reset, `done`, `resA`, `resB`, `flagC` and `flagOv` are all zero.
- R2: With `opDiv` = 0 (multiply), `resA` is bits 7..0 and `resB` is bits 15..8 of the unsigned product `opA * opB`.
- R3: A multiply sets `flagOv` when the product exceeds 255 and clears it otherwise.
- R4: With `opDiv` = 1 (divide) and a nonzero `opB`, `resA` is the quotient `opA / opB`, `resB` is the remainder `opA % opB`, and `flagOv` is cleared.
- R5: A divide with `opB` = 0 sets `flagOv`. The unit leaves the operands unchanged, so `resA` equals the captured `opA` and `resB` equals the captured `opB` (zero).
- R6: Every completed operation, multiply or divide, clears `flagC`.
- R7: If `startReq` is sampled high at clock edge N while the unit is idle, `done` is high only in the cycle after edge N+8 and low in the cycles after edges N through N+7 and N+9.
- R8: A `startReq` that arrives while an operation is running is ignored. The running operation finishes with its own operands and timing, and no extra `done` follows.
- R9: The unit captures its operands at the start edge. `resA`, `resB`, `flagC` and `flagOv` hold their values between completions, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start an operation (ignored while one is running) |
| opDiv | input | 1 | Operation select: 0 multiply, 1 divide |
| opA | input | 8 | Accumulator operand (multiplier or dividend) |
| opB | input | 8 | Auxiliary operand (multiplicand or divisor) |
| resA | output | 8 | New accumulator value |
| resB | output | 8 | New auxiliary value |
| flagC | output | 1 | Carry flag result |
| flagOv | output | 1 | Overflow flag result |
| done | output | 1 | One-cycle completion pulse |

## Verification
All four results and the done pulse become valid together, eight clock edges after the edge that captures the start request. The bench drives inputs and samples outputs on falling edges. For each operation it counts the falling edges that follow the capturing edge. It requires `done` to be low at the first eight samples and high at the ninth, where it compares the results and flags. It then requires `done` to be low again at the tenth. In the busy-start test, the bench injects a second request mid-run with different operands. It then checks that the completion still arrives at the ninth sample with the first operation's results, and that no further pulse follows.

// File: rtl/md_pkg.sv
package md_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands, clear working registers
    logic step;   // perform one bit iteration
    logic last;   // this step is the final one: publish results
  } mdStrobe_t;

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import md_pkg::*;
#(
  parameter int ITER = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output mdStrobe_t  strb,
  output logic       done
);

  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITER - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    strb.load = (state == ST_IDLE) && startReq;
    strb.step = (state == ST_RUN);
    strb.last = (state == ST_RUN) && (iterCnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.last;
      if (strb.load) begin
        state   <= ST_RUN;
        iterCnt <= '0;
      end else if (strb.step) begin
        iterCnt <= iterCnt + 1'b1;
        if (strb.last) state <= ST_IDLE;
      end
    end
  end

  // R7
  start_to_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (strb.step && !done));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.last) |=> (strb.step && !strb.load));

endmodule

// File: rtl/md_datapath.sv
module md_datapath
  import md_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strb,
  input  logic             opDiv,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resA,
  output logic [WIDTH-1:0] resB,
  output logic             flagC,
  output logic             flagOv
);

  logic             isDiv;
  logic [WIDTH-1:0] origA;
  logic [WIDTH-1:0] operandB;
  logic [WIDTH-1:0] hiReg;
  logic [WIDTH-1:0] loReg;

  // Multiply step: conditional add into the high half, then shift right
  logic [WIDTH:0]   mulSum;
  logic [WIDTH-1:0] mulHi, mulLo;

  // Divide step: shift left one dividend bit into the remainder, trial subtract
  logic [WIDTH:0]   divShift;
  logic             divFits;
  logic [WIDTH-1:0] divRem;
  logic [WIDTH-1:0] divHi, divLo;

  logic [WIDTH-1:0] nextHi, nextLo;
  logic             divByZero;

  always_comb begin
    mulSum   = {1'b0, hiReg} + (loReg[0] ? {1'b0, operandB} : '0);
    mulHi    = mulSum[WIDTH:1];
    mulLo    = {mulSum[0], loReg[WIDTH-1:1]};

    divShift = {hiReg, loReg[WIDTH-1]};
    divFits  = (divShift >= {1'b0, operandB});
    divRem   = divShift[WIDTH-1:0] - operandB;
    divHi    = divFits ? divRem : divShift[WIDTH-1:0];
    divLo    = {loReg[WIDTH-2:0], divFits};

    nextHi    = isDiv ? divHi : mulHi;
    nextLo    = isDiv ? divLo : mulLo;
    divByZero = (operandB == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isDiv    <= 1'b0;
      origA    <= '0;
      operandB <= '0;
      hiReg    <= '0;
      loReg    <= '0;
      resA     <= '0;
      resB     <= '0;
      flagC    <= 1'b0;
      flagOv   <= 1'b0;
    end else if (strb.load) begin
      isDiv    <= opDiv;
      origA    <= opA;
      operandB <= opB;
      hiReg    <= '0;
      loReg    <= opA;
    end else if (strb.step) begin
      hiReg <= nextHi;
      loReg <= nextLo;
      if (strb.last) begin
        flagC <= 1'b0;
        if (isDiv && divByZero) begin
          resA   <= origA;
          resB   <= operandB;
          flagOv <= 1'b1;
        end else begin
          resA   <= nextLo;
          resB   <= nextHi;
          flagOv <= isDiv ? 1'b0 : (nextHi != '0);
        end
      end
    end
  end

  // R3
  mul_ov_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.last) && !isDiv) |-> (flagOv == (resB != '0)));

  // R4
  div_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.last) && isDiv && !divByZero) |-> (!flagOv && (resB < operandB)));

  // R5
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.last) && isDiv && divByZero) |-> (flagOv && (resA == origA)));

  // R6
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.last) |-> !flagC);

endmodule

// File: rtl/md_unit.sv
module md_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             opDiv,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resA,
  output logic [WIDTH-1:0] resB,
  output logic             flagC,
  output logic             flagOv,
  output logic             done
);

  md_pkg::mdStrobe_t strb;

  md_ctrl #(.ITER(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strb     (strb),
    .done     (done)
  );

  md_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opDiv  (opDiv),
    .opA    (opA),
    .opB    (opB),
    .resA   (resA),
    .resB   (resB),
    .flagC  (flagC),
    .flagOv (flagOv)
  );

endmodule

// File: tb/md_unit_tb.sv
module md_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       opDiv = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] resA, resB;
  logic       flagC, flagOv, done;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  md_unit u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opDiv(opDiv),
    .opA(opA), .opB(opB), .resA(resA), .resB(resB),
    .flagC(flagC), .flagOv(flagOv), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkResult(input bit div, input int a, input int b);
    int p, eA, eB, eOv;
    if (!div) begin
      p = a * b;
      eA = p % 256; eB = p / 256; eOv = (p > 255) ? 1 : 0;
      check(resA == eA[7:0] && resB == eB[7:0], "R2", "product {A,B}",
            {resB, resA}, p);
      check(flagOv == eOv[0], "R3", "mul OV", flagOv, eOv);
    end else if (b == 0) begin
      check(flagOv == 1'b1 && resA == a[7:0] && resB == 8'd0, "R5",
            "div0 {OV,A,B}", {flagOv, resA, resB}, {1'b1, a[7:0], 8'd0});
    end else begin
      eA = a / b; eB = a % b;
      check(resA == eA[7:0] && resB == eB[7:0] && !flagOv, "R4",
            "div {OV,A,B}", {flagOv, resA, resB}, {1'b0, eA[7:0], eB[7:0]});
    end
    check(flagC == 1'b0, "R6", "C flag", flagC, 0);
  endtask

  // Start one operation and follow it to completion, checking timing (R7)
  task automatic runOp(input bit div, input int a, input int b);
    bit earlyDone = 0;
    @(negedge clk);
    opDiv = div; opA = a[7:0]; opB = b[7:0]; startReq = 1'b1;
    @(negedge clk);            // after capturing edge N
    startReq = 1'b0;
    opA = ~a[7:0]; opB = ~b[7:0];  // operands must already be captured (R9)
    for (int i = 0; i < 8; i++) begin
      if (done) earlyDone = 1;
      @(negedge clk);
    end
    check(!earlyDone && done, "R7", "done at ninth sample", done, 1);
    checkResult(div, a, b);
    @(negedge clk);
    check(!done, "R7", "done falls after one cycle", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] holdA, holdB;
    logic       holdOv;
    bit         extraDone;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && resA == 0 && resB == 0 && !flagC && !flagOv, "R1",
          "reset outputs", {done, resA, resB, flagC, flagOv}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && resA == 0 && resB == 0, "R1", "idle after reset",
          {done, resA, resB}, 0);

    // Grid sweep of both operations
    for (int a = 0; a < 256; a += 9)
      for (int b = 0; b < 256; b += 11) begin
        runOp(1'b0, a, b);
        runOp(1'b1, a, b);
      end
    // Full divisor/multiplicand sweep with the largest A
    for (int b = 0; b < 256; b++) begin
      runOp(1'b0, 255, b);
      runOp(1'b1, 255, b);
    end
    // Division by zero with every dividend (R5)
    for (int a = 0; a < 256; a++) runOp(1'b1, a, 0);
    // Divisor 1 and dividend smaller than divisor
    runOp(1'b1, 200, 1);
    runOp(1'b1, 3, 250);
    runOp(1'b0, 16, 16);
    runOp(1'b0, 15, 17);

    // R9: results hold while inputs wander and no start arrives
    runOp(1'b0, 200, 3);
    holdA = resA; holdB = resB; holdOv = flagOv;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opA = 8'(i * 37); opB = 8'(i * 53); opDiv = i[0];
    end
    check(resA == holdA && resB == holdB && flagOv == holdOv && !done, "R9",
          "held results", {resA, resB, flagOv}, {holdA, holdB, holdOv});

    // R8: start while busy is ignored
    @(negedge clk);
    opDiv = 1'b0; opA = 8'd12; opB = 8'd13; startReq = 1'b1;
    @(negedge clk);            // after edge N
    startReq = 1'b0;
    @(negedge clk);
    @(negedge clk);            // after edge N+2
    opDiv = 1'b1; opA = 8'd200; opB = 8'd7; startReq = 1'b1;
    @(negedge clk);            // after edge N+3
    startReq = 1'b0;
    for (int i = 0; i < 5; i++) @(negedge clk);  // after edge N+8
    check(done && resA == 8'd156 && resB == 8'd0 && !flagOv, "R8",
          "busy start ignored", {done, resA, resB}, {1'b1, 8'd156, 8'd0});
    extraDone = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) extraDone = 1;
    end
    check(!extraDone && resA == 8'd156, "R8", "no second completion",
          {extraDone, resA}, {1'b0, 8'd156});

    // Unit accepts a new start after the ignored request
    runOp(1'b1, 200, 7);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule